// File: doc/BRIEF.md
# Two-Stage Mode-Register-Set Sequencer

This block programs the mode register of external synchronous ROM devices. A host places a 15-bit mode word on a write port for one cycle. That single write starts a fixed sequence of two command stages. The first stage addresses the lower bank pair (banks 0 and 1) and the second addresses the upper pair (banks 2 and 3). During each stage the stored word sits on the memory address bus, which carries memory address bits 24 down to 10. The row strobe, column strobe and write strobe are driven low together, and chip selects are driven low only for the banks that qualify.

A bank qualifies when its enable bit is set and its memory-type field holds the synchronous ROM code. Both come from a configuration input that a separate register owns. The mode word register holds only the word itself. CAS latency and the other device settings live in that configuration input. When reset is released and the boot strap says the system boots from synchronous ROM, the sequencer runs once by itself with a built-in default word. The host does not have to write anything for this.

Top module: `modeset_seq`

## Requirements
- R1: While reset is asserted and right after it: busy, done and err are low, cs_n is all ones, ras_n, cas_n and we_n are high, and ma is zero.
- R2: A host write (wr_en high at a clock edge while busy is low) loads wr_data into the mode register and starts the sequence. busy goes high after that edge and stays high for 2*HOLD_CYCLES+2 cycles.
- R3: During a command stage, ras_n, cas_n and we_n are all low and ma equals the stored mode word. Outside command stages these three lines are high, every cs_n bit is high and ma is zero.
- R4: Stage one can assert only cs_n[0] and cs_n[1], and stage two can assert only cs_n[2] and cs_n[3]. The two pairs are never low at the same time.
- R5: cs_n[b] is driven low in its stage only when bank_en[b] is 1 and bank_type[2b+1:2b] equals 2'b10, the synchronous ROM code.
- R6: A stage whose pair has no qualifying bank still drives the command and address for its full length, with both of its chip selects high.
- R7: Each stage lasts HOLD_CYCLES cycles (default 2), and exactly one idle cycle follows each stage.
- R8: done is high for exactly one cycle, the idle cycle that follows stage two. That cycle is the last one in which busy is high.
- R9: A host write that arrives while busy is high does not change the mode word or the running sequence. It sets err, and err stays set until reset.
- R10: If boot_rom is high when reset is released, the block runs one sequence carrying BOOT_VALUE, starting at the first clock edge after release, with no host write. If boot_rom is low, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_rom | input | 1 | Boot strap: high when booting from synchronous ROM |
| wr_en | input | 1 | Host write strobe for the mode word |
| wr_data | input | 15 | Mode word written by the host |
| bank_en | input | 4 | Per-bank enable from the configuration input |
| bank_type | input | 8 | Per-bank 2-bit memory type; 2'b10 is synchronous ROM |
| ma | output | 15 | Memory address bits 24..10 |
| cs_n | output | 4 | Active-low chip selects, one per bank |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| err | output | 1 | Sticky flag: a write was rejected while busy |

## Verification
The bench runs all 16 enable patterns, each against several type patterns. Some of those type patterns contain no ROM bank in a pair, so it catches a design that lets a non-ROM or disabled bank through. It also catches a design that drops or shortens a stage that has nothing to select, and one that swaps the pairs. Each sequence is compared cycle by cycle, so a stage that is one cycle off, a missing gap cycle, or a done pulse in the wrong cycle shows up as a mismatch. A write in the middle of a sequence checks that the address bus keeps the old word and that err latches and stays latched. A design that reloaded or restarted on that write would fail this test. Reset with the strap high and then low shows whether the power-up command is issued at all, and whether it carries the default word.

// File: rtl/modeset_pkg.sv
package modeset_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_STAGE_A,
      PH_GAP_A,
      PH_STAGE_B,
      PH_GAP_B
   } phase_t;
endpackage

// File: rtl/modeset_phase.sv
module modeset_phase
   import modeset_pkg::*;
#(
   parameter int HOLD_CYCLES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_t phase
);
   localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
   localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES - 1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         remain <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase  <= PH_STAGE_A;
                  remain <= RELOAD;
               end
            end
            PH_STAGE_A: begin
               if (remain == '0) phase <= PH_GAP_A;
               else              remain <= remain - 1'b1;
            end
            PH_GAP_A: begin
               phase  <= PH_STAGE_B;
               remain <= RELOAD;
            end
            PH_STAGE_B: begin
               if (remain == '0) phase <= PH_GAP_B;
               else              remain <= remain - 1'b1;
            end
            PH_GAP_B: phase <= PH_IDLE;
            default:  phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/modeset_wordreg.sv
module modeset_wordreg #(
   parameter int               ADDR_W     = 15,
   parameter logic [ADDR_W-1:0] BOOT_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              boot_rom,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] word,
   output logic              start,
   output logic              err
);
   logic boot_pend;
   logic accept;

   assign accept = wr_en && !busy;
   assign start  = accept || (boot_pend && boot_rom && !busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word      <= BOOT_VALUE;
         err       <= 1'b0;
         boot_pend <= 1'b1;
      end else begin
         boot_pend <= 1'b0;
         if (accept)        word <= wr_data;
         if (wr_en && busy) err  <= 1'b1;
      end
   end
endmodule

// File: rtl/modeset_csgate.sv
module modeset_csgate
   import modeset_pkg::*;
#(
   parameter int                NUM_BANKS = 4,
   parameter int                TYPE_W    = 2,
   parameter logic [TYPE_W-1:0] ROM_CODE  = 2'b10
) (
   input  phase_t                      phase,
   input  logic [NUM_BANKS-1:0]        bank_en,
   input  logic [NUM_BANKS*TYPE_W-1:0] bank_type,
   output logic [NUM_BANKS-1:0]        cs_n
);
   localparam int HALF = NUM_BANKS / 2;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic qual;
      logic in_stage;
      assign qual = bank_en[b] && (bank_type[b*TYPE_W +: TYPE_W] == ROM_CODE);
      if (b < HALF) begin : g_low
         assign in_stage = (phase == PH_STAGE_A);
      end else begin : g_high
         assign in_stage = (phase == PH_STAGE_B);
      end
      assign cs_n[b] = !(qual && in_stage);
   end
endmodule

// File: rtl/modeset_seq.sv
module modeset_seq
   import modeset_pkg::*;
#(
   parameter int                ADDR_W      = 15,
   parameter int                NUM_BANKS   = 4,
   parameter int                TYPE_W      = 2,
   parameter logic [TYPE_W-1:0] ROM_CODE    = 2'b10,
   parameter int                HOLD_CYCLES = 2,
   parameter logic [ADDR_W-1:0] BOOT_VALUE  = 15'h0032
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        boot_rom,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_data,
   input  logic [NUM_BANKS-1:0]        bank_en,
   input  logic [NUM_BANKS*TYPE_W-1:0] bank_type,
   output logic [ADDR_W-1:0]           ma,
   output logic [NUM_BANKS-1:0]        cs_n,
   output logic                        ras_n,
   output logic                        cas_n,
   output logic                        we_n,
   output logic                        busy,
   output logic                        done,
   output logic                        err
);
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("modeset_seq: HOLD_CYCLES must be at least 1");
   end
   if ((NUM_BANKS < 2) || (NUM_BANKS % 2 != 0)) begin : g_bad_banks
      $error("modeset_seq: NUM_BANKS must be even and at least 2");
   end
   if (ADDR_W < 1 || TYPE_W < 1) begin : g_bad_width
      $error("modeset_seq: widths must be positive");
   end

   phase_t            phase;
   logic [ADDR_W-1:0] word;
   logic              start;
   logic              cmd_on;

   assign busy   = (phase != PH_IDLE);
   assign cmd_on = (phase == PH_STAGE_A) || (phase == PH_STAGE_B);
   assign done   = (phase == PH_GAP_B);
   assign ras_n  = !cmd_on;
   assign cas_n  = !cmd_on;
   assign we_n   = !cmd_on;
   assign ma     = cmd_on ? word : '0;

   modeset_wordreg #(
      .ADDR_W    (ADDR_W),
      .BOOT_VALUE(BOOT_VALUE)
   ) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .boot_rom(boot_rom),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .word    (word),
      .start   (start),
      .err     (err)
   );

   modeset_phase #(
      .HOLD_CYCLES(HOLD_CYCLES)
   ) u_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .phase(phase)
   );

   modeset_csgate #(
      .NUM_BANKS(NUM_BANKS),
      .TYPE_W   (TYPE_W),
      .ROM_CODE (ROM_CODE)
   ) u_cs (
      .phase    (phase),
      .bank_en  (bank_en),
      .bank_type(bank_type),
      .cs_n     (cs_n)
   );
endmodule

// File: rtl/modeset_seq_chk.sv
module modeset_seq_chk #(
   parameter int                ADDR_W    = 15,
   parameter int                NUM_BANKS = 4,
   parameter int                TYPE_W    = 2,
   parameter logic [TYPE_W-1:0] ROM_CODE  = 2'b10
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_en,
   input logic [NUM_BANKS-1:0]        bank_en,
   input logic [NUM_BANKS*TYPE_W-1:0] bank_type,
   input logic [ADDR_W-1:0]           ma,
   input logic [NUM_BANKS-1:0]        cs_n,
   input logic                        ras_n,
   input logic                        cas_n,
   input logic                        we_n,
   input logic                        busy,
   input logic                        done,
   input logic                        err
);
   localparam int HALF = NUM_BANKS / 2;

   assert_cmd_lines_tied_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n == cas_n) && (cas_n == we_n));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ras_n && (&cs_n) && (ma == '0)));

   assert_cs_needs_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(&cs_n) |-> !ras_n);

   assert_pairs_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!(&cs_n[HALF-1:0]) && !(&cs_n[NUM_BANKS-1:HALF])));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_q
      assert_cs_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !cs_n[b] |-> (bank_en[b] && (bank_type[b*TYPE_W +: TYPE_W] == ROM_CODE)));
   end

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_in_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy && ras_n));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   assert_busy_write_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> err);

   assert_ma_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && $past(!ras_n)) |-> $stable(ma));
endmodule

bind modeset_seq modeset_seq_chk #(
   .ADDR_W   (ADDR_W),
   .NUM_BANKS(NUM_BANKS),
   .TYPE_W   (TYPE_W),
   .ROM_CODE (ROM_CODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .bank_en  (bank_en),
   .bank_type(bank_type),
   .ma       (ma),
   .cs_n     (cs_n),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .we_n     (we_n),
   .busy     (busy),
   .done     (done),
   .err      (err)
);

// File: tb/modeset_seq_test.sv
`timescale 1ns/1ps
module modeset_seq_test;
   localparam int          AW   = 15;
   localparam int          NB   = 4;
   localparam int          TW   = 2;
   localparam logic [1:0]  ROM  = 2'b10;
   localparam int          H    = 2;
   localparam logic [14:0] BOOT = 15'h0032;
   localparam int          LAST = 2*H + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          boot_rom = 1'b0;
   logic          wr_en = 1'b0;
   logic [14:0]   wr_data = '0;
   logic [3:0]    bank_en = '0;
   logic [7:0]    bank_type = '0;
   logic [14:0]   ma;
   logic [3:0]    cs_n;
   logic          ras_n, cas_n, we_n, busy, done, err;
   logic [24:0]   obs;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   modeset_seq #(
      .ADDR_W(AW), .NUM_BANKS(NB), .TYPE_W(TW), .ROM_CODE(ROM),
      .HOLD_CYCLES(H), .BOOT_VALUE(BOOT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .boot_rom(boot_rom), .wr_en(wr_en),
      .wr_data(wr_data), .bank_en(bank_en), .bank_type(bank_type),
      .ma(ma), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .busy(busy), .done(done), .err(err)
   );

   assign obs = {ras_n, cas_n, we_n, cs_n, ma, busy, done, err};

   // Expected port picture at cycle i after the starting edge (i = LAST is idle).
   function automatic logic [24:0] expect_at(int i, logic [14:0] v, logic [3:0] en,
                                             logic [7:0] ty, logic er);
      logic       st_a, st_b, cmd, bz, dn;
      logic [3:0] cs;
      st_a = (i < H);
      st_b = (i > H) && (i < 2*H + 1);
      cmd  = st_a || st_b;
      bz   = (i <= 2*H + 1);
      dn   = (i == 2*H + 1);
      for (int b = 0; b < 4; b++) begin
         logic q;
         q = en[b] && (ty[2*b +: 2] == ROM);
         cs[b] = !(q && ((b < 2) ? st_a : st_b));
      end
      return {!cmd, !cmd, !cmd, cs, cmd ? v : 15'h0, bz, dn, er};
   endfunction

   task automatic observe(input string req, input int i, input logic [14:0] v,
                          input logic [3:0] en, input logic [7:0] ty, input logic er);
      logic [24:0] e;
      e = expect_at(i, v, en, ty, er);
      n_chk++;
      if (obs !== e) begin
         n_err++;
         $display("FAIL %s cycle %0d: actual %h expected %h", req, i, obs, e);
      end
   endtask

   task automatic run_write(input logic [14:0] v, input logic [3:0] en,
                            input logic [7:0] ty, input logic er, input string req);
      @(negedge clk);
      bank_en = en; bank_type = ty; wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 0; i <= LAST; i++) begin
         observe(req, i, v, en, ty, er);
         if (i < LAST) @(negedge clk);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      // R1 and R10: reset with boot strap high
      boot_rom = 1'b1; bank_en = 4'hF; bank_type = 8'hAA;
      repeat (3) @(negedge clk);
      observe("R1 reset state", LAST, 15'h0, 4'hF, 8'hAA, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i <= LAST; i++) begin
         observe("R10 boot sequence", i, BOOT, 4'hF, 8'hAA, 1'b0);
         if (i < LAST) @(negedge clk);
      end

      // R2 R3 R4 R5 R6 R7 R8: sweep all enables over several type patterns
      for (int en = 0; en < 16; en++) begin
         for (int t = 0; t < 4; t++) begin
            logic [7:0]  ty;
            logic [14:0] v;
            ty = 8'(en * 29 + t * 83);
            if (t == 0) ty = 8'hAA;
            v  = 15'(en * 1021 + t * 331) ^ 15'h25a5;
            run_write(v, 4'(en), ty, 1'b0, "R2 R3 R4 R5 R6 R7 R8 sweep");
         end
      end

      // R6: no qualifying bank anywhere, timing unchanged
      run_write(15'h7fff, 4'hF, 8'h55, 1'b0, "R6 empty stages");

      // R3: idle stays quiet
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         observe("R3 idle", LAST, 15'h0, 4'h0, 8'h0, 1'b0);
      end

      // R9: write while busy is ignored and raises sticky err
      @(negedge clk);
      bank_en = 4'hF; bank_type = 8'hAA; wr_en = 1'b1; wr_data = 15'h1234;
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 0; i <= LAST; i++) begin
         observe("R9 ignored write", i, 15'h1234, 4'hF, 8'hAA, i >= 2);
         if (i == 1) wr_data = 15'h4321;
         if (i == 1) wr_en = 1'b1;
         if (i < LAST) @(negedge clk);
         wr_en = 1'b0;
      end
      run_write(15'h0f0f, 4'h9, 8'hAA, 1'b1, "R9 err sticky");

      // R10 and R1: reset with strap low stays idle, err cleared
      @(negedge clk);
      rst_n = 1'b0; boot_rom = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         observe("R10 no boot", LAST, 15'h0, 4'hF, 8'hAA, 1'b0);
      end
      run_write(15'h2a2a, 4'h6, 8'hAA, 1'b0, "R2 after plain reset");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule